// File: doc/BRIEF.md
# Two-Operand ALU with Condition Flags

A combinational arithmetic and logic unit that takes two operand words and a 2-bit function select and returns a result word. The four functions are addition, subtraction, bitwise AND and bitwise XOR. Each function also produces three condition flags: zero, carry and signed overflow. The flag rules depend on the selected function.

A registered copy of the flags is updated on a rising clock edge when the flag-update enable is high. Otherwise the copy keeps its value. Downstream logic can therefore test flags set by an earlier operation while the combinational outputs follow the current inputs. The word width is set by a parameter.

Top module: `alu_flags`

## Requirements
- R1: op_i = 2'b00 gives res_o = a_i + b_i modulo 2^W.
- R2: op_i = 2'b01 gives res_o = a_i - b_i modulo 2^W.
- R3: op_i = 2'b10 gives res_o = a_i & b_i, and op_i = 2'b11 gives res_o = a_i ^ b_i.
- R4: zf_o is 1 exactly when res_o is all zeros, for every function.
- R5: For addition, cf_o is the carry out of bit W-1. For subtraction, cf_o is 1 exactly when b_i > a_i as unsigned values (borrow).
- R6: For addition, of_o is 1 when both operands have the same sign bit and the result sign bit differs from it. For subtraction, of_o is 1 when the operand sign bits differ and the result sign bit differs from the sign bit of a_i.
- R7: For AND and XOR, cf_o and of_o are 0.
- R8: The flag register {zf_q_o, cf_q_o, of_q_o} clears to 0 while rst_ni is low. On a rising clk_i edge with set_cc_i = 1 it loads the current zf_o, cf_o and of_o. With set_cc_i = 0 it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the flag register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| op_i | input | 2 | Function: 0 add, 1 sub, 2 and, 3 xor |
| set_cc_i | input | 1 | Flag register load enable |
| res_o | output | W | Result word |
| zf_o | output | 1 | Zero flag (combinational) |
| cf_o | output | 1 | Carry/borrow flag (combinational) |
| of_o | output | 1 | Signed overflow flag (combinational) |
| zf_q_o | output | 1 | Registered zero flag |
| cf_q_o | output | 1 | Registered carry flag |
| of_q_o | output | 1 | Registered overflow flag |

## Verification
The combinational assertions assume that a_i, b_i and op_i hold known, stable values when they are sampled. The bench changes these inputs only on the falling clock edge, so every sample on a rising edge sees settled operands. The flag-register assertions assume that set_cc_i is never unknown after reset. The bench drives it to a defined level from time zero, and it drives set_cc_i on the same falling edge as the operands so that each capture takes the flags of a single, stable operation.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    FN_ADD = 2'd0,
    FN_SUB = 2'd1,
    FN_AND = 2'd2,
    FN_XOR = 2'd3
  } alu_fn_e;

  typedef struct packed {
    logic zf;
    logic cf;
    logic of;
  } flags_t;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cf_o,
  output logic         of_o
);
  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  // Subtraction is done as a + ~b + 1. The borrow is the inverted carry out.
  assign b_eff = sub_i ? ~b_i : b_i;
  assign wide  = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
  assign sum_o = wide[W-1:0];
  assign cf_o  = wide[W] ^ sub_i;
  assign of_o  = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);

  always_comb begin
    // R5: a borrow occurs exactly when b > a (unsigned)
    if (sub_i) p_borrow_r5: assert (cf_o == (b_i > a_i));
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         xor_i,
  output logic [W-1:0] res_o
);
  assign res_o = xor_i ? (a_i ^ b_i) : (a_i & b_i);
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   en_i,
  input  flags_t d_i,
  output flags_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(q_o));
  p_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (q_o == $past(d_i)));
endmodule

// File: rtl/alu_flags.sv
module alu_flags
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   op_i,
  input  logic         set_cc_i,
  output logic [W-1:0] res_o,
  output logic         zf_o,
  output logic         cf_o,
  output logic         of_o,
  output logic         zf_q_o,
  output logic         cf_q_o,
  output logic         of_q_o
);
  localparam int MSB = W - 1;

  logic [W-1:0] arith_res, logic_res;
  logic         arith_cf, arith_of, is_arith;
  flags_t       cur_flags, reg_flags;

  assign is_arith = ~op_i[1];

  alu_addsub #(.W(W)) u_addsub (
    .a_i(a_i), .b_i(b_i), .sub_i(op_i[0]),
    .sum_o(arith_res), .cf_o(arith_cf), .of_o(arith_of)
  );

  alu_logic #(.W(W)) u_logic (
    .a_i(a_i), .b_i(b_i), .xor_i(op_i[0]), .res_o(logic_res)
  );

  assign res_o = is_arith ? arith_res : logic_res;
  assign zf_o  = (res_o == '0);
  assign cf_o  = is_arith & arith_cf;
  assign of_o  = is_arith & arith_of;

  assign cur_flags = '{zf: zf_o, cf: cf_o, of: of_o};

  alu_flag_reg u_flag_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(set_cc_i),
    .d_i(cur_flags), .q_o(reg_flags)
  );

  assign zf_q_o = reg_flags.zf;
  assign cf_q_o = reg_flags.cf;
  assign of_q_o = reg_flags.of;

  p_no_logic_flags_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i[1] |-> (!cf_o && !of_o));
  p_add_of_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == FN_ADD && a_i[MSB] == b_i[MSB]) |-> (of_o == (res_o[MSB] != a_i[MSB])));
  p_sub_of_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == FN_SUB && a_i[MSB] == b_i[MSB]) |-> !of_o);
  p_sub_res_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == FN_SUB) |-> (res_o + b_i == a_i));
  p_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zf_o |-> ($countones(res_o) == 0));
endmodule

// File: tb/tb_alu_flags.sv
module tb_alu_flags;
  localparam int W = 32;

  logic         clk = 0, rst_ni = 0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic [1:0]   op_i = '0;
  logic         set_cc_i = 0;
  logic [W-1:0] res_o;
  logic         zf_o, cf_o, of_o, zf_q_o, cf_q_o, of_q_o;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  alu_flags #(.W(W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .op_i(op_i),
    .set_cc_i(set_cc_i), .res_o(res_o), .zf_o(zf_o), .cf_o(cf_o), .of_o(of_o),
    .zf_q_o(zf_q_o), .cf_q_o(cf_q_o), .of_q_o(of_q_o)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Independent reference model
  task automatic apply(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] r; logic c, o;
    @(negedge clk); op_i = op; a_i = a; b_i = b; #1;
    c = 0; o = 0;
    case (op)
      2'd0: begin r = a + b; c = ({1'b0, a} + {1'b0, b}) > {1'b0, {W{1'b1}}};
                  o = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]); end
      2'd1: begin r = a - b; c = b > a;
                  o = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]); end
      2'd2: r = a & b;
      default: r = a ^ b;
    endcase
    chk(op == 0 ? "R1" : op == 1 ? "R2" : "R3", res_o, r);
    chk("R4", {31'b0, zf_o}, {31'b0, r == '0});
    chk(op[1] ? "R7 cf" : "R5", {31'b0, cf_o}, {31'b0, c});
    chk(op[1] ? "R7 of" : "R6", {31'b0, of_o}, {31'b0, o});
  endtask

  task automatic t_reset;
    chk("R8 reset", {29'b0, zf_q_o, cf_q_o, of_q_o}, '0);
  endtask

  task automatic t_add;
    apply(0, 32'd5, 32'd7);
    apply(0, 32'hFFFF_FFFF, 32'd1);
    apply(0, 32'h7FFF_FFFF, 32'd1);
    apply(0, 32'h8000_0000, 32'h8000_0000);
  endtask

  task automatic t_sub;
    apply(1, 32'd9, 32'd9);
    apply(1, 32'd3, 32'd4);
    apply(1, 32'h8000_0000, 32'd1);
    apply(1, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    apply(1, 32'd0, 32'h8000_0000);
  endtask

  task automatic t_logic;
    apply(2, 32'hF0F0_F0F0, 32'h0F0F_0F0F);
    apply(2, 32'hFFFF_FFFF, 32'h8000_0001);
    apply(3, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
    apply(3, 32'hFFFF_FFFF, 32'h8000_0000);
  endtask

  task automatic t_flag_reg;
    // Load from 0x7FFFFFFF + 1: zf=0 cf=0 of=1
    apply(0, 32'h7FFF_FFFF, 32'd1);
    set_cc_i = 1; @(negedge clk); set_cc_i = 0;
    chk("R8 load", {29'b0, zf_q_o, cf_q_o, of_q_o}, 3'b001);
    // New flags (zf=1) without enable: the register holds
    apply(3, 32'd4, 32'd4);
    @(negedge clk);
    chk("R8 hold", {29'b0, zf_q_o, cf_q_o, of_q_o}, 3'b001);
    // Load borrow case 0 - 1: zf=0 cf=1 of=0
    apply(1, 32'd0, 32'd1);
    set_cc_i = 1; @(negedge clk); set_cc_i = 0;
    chk("R8 load2", {29'b0, zf_q_o, cf_q_o, of_q_o}, 3'b010);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1; t_reset();
    @(negedge clk); @(negedge clk); rst_ni = 1;
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_flag_reg();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule